// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps a small direct-mapped set of one-word lines coherent on a snooping bus. Each line is Modified, Exclusive, Shared or Invalid. Processor reads and writes that hit are served locally. A miss, or a write to a line that other caches may hold, raises a read or read-for-ownership request on the bus. On a read miss the controller samples a wired-OR shared signal. This signal tells it whether another cache holds the line, and so whether the fill lands Exclusive or Shared. Because of this, a later write to an unshared line completes without any bus traffic.

On the snoop side, the controller watches the transactions of other caches. It asserts its shared output when a snooped read hits a valid copy. It supplies the line cache-to-cache over a flush port when it holds the line Modified or Exclusive, and it demotes or invalidates the line as the protocol requires. A Shared holder never supplies data, so at most one cache drives a flush. A flush of dirty data also carries a memory-update flag. The same flush port writes back a Modified victim before a miss reuses its slot.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpu_ready, bus_req_valid, flush_valid and shared_out are all low.
- R2: A read miss raises bus_req_valid with bus_req_cmd = 1 (read) and the line address, and holds the request until bus_gnt. shared_in is sampled only in the cycle after the grant cycle: 0 installs the line Exclusive, 1 installs it Shared. cpu_rdata returns the fill word.
- R3: A processor write to an Exclusive line makes it Modified with no bus request, and cpu_ready pulses in the cycle after acceptance.
- R4: A processor write to a Shared or Invalid line raises bus_req_cmd = 2 (read-for-ownership). The line is then installed Modified holding the write data, and cpu_rdata echoes that data.
- R5: A snooped read (snp_cmd = 1) that hits a Modified line produces, one cycle later, flush_valid with the line data and flush_mem_wr = 1, together with shared_out = 1. The line becomes Shared.
- R6: A snooped read that hits an Exclusive line supplies the data on the flush port with flush_mem_wr = 0 and asserts shared_out. The line becomes Shared.
- R7: A snooped read-for-ownership (snp_cmd = 2) that hits a Modified or Exclusive line flushes the data and invalidates the line. flush_mem_wr is 1 only for Modified.
- R8: A snooped read-for-ownership that hits a Shared line invalidates it with no flush and no shared_out.
- R9: A snooped read that hits a Shared line asserts shared_out without flushing, and the line stays Shared.
- R10: A snoop to an Invalid line, or to a line whose tag differs (index = low address bits), produces no output and changes no state.
- R11: A read hit returns the stored word with cpu_ready in the cycle after acceptance, and raises no bus request.
- R12: When a miss displaces a Modified line of another tag, that line is flushed with its own address, its data and flush_mem_wr = 1 before the bus request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, or the written data for writes |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 = read, 2 = read-for-ownership |
| bus_req_addr | output | ADDR_W | Requested line address |
| bus_gnt | input | 1 | Address phase of the request (one cycle) |
| bus_fill_valid | input | 1 | Fill data present |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | 1 = read, 2 = read-for-ownership |
| snp_addr | input | ADDR_W | Snooped line address |
| shared_in | input | 1 | Wired-OR shared signal from the bus |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_valid | output | 1 | Line data driven on the flush port |
| flush_addr | output | ADDR_W | Address of the flushed line |
| flush_data | output | DATA_W | Flushed word |
| flush_mem_wr | output | 1 | Memory must capture the flushed word (dirty data) |

## Verification
The bench drives shared_in to the opposite value in every cycle except the one after the grant. A controller that samples the signal on the grant cycle or during the fill would therefore install the wrong state, and the next snoop would show it as a missing or extra flush. The bench reads the line state back through snoops: Exclusive shows as a flush without a memory update, and Modified as a flush with one. A design that forgot the silent Exclusive-to-Modified write, or that let Shared holders supply data, would show a spurious bus command or flush. The bench also exercises a snoop with a matching index but a different tag, and an eviction of a dirty victim. A design that compared only the index would answer the first. A design that dropped the victim or flushed it after the request would fail the second.

// File: rtl/mesi_ctl_pkg.sv
package mesi_ctl_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2
  } bus_cmd_e;

  typedef struct packed {
    logic     flush;
    logic     mem_wr;
    logic     shared;
    line_st_e nxt;
  } snp_resp_t;

  // Response of a holder to a transaction seen from another cache.
  function automatic snp_resp_t snoop_react(line_st_e st, bus_cmd_e cmd);
    snp_resp_t r;
    r.flush  = 1'b0;
    r.mem_wr = 1'b0;
    r.shared = 1'b0;
    r.nxt    = st;
    if (cmd == BC_RD) begin
      r.shared = (st != LS_I);
      if (st == LS_M || st == LS_E) begin
        r.flush  = 1'b1;
        r.mem_wr = (st == LS_M);
        r.nxt    = LS_S;
      end
    end else if (cmd == BC_RDX) begin
      if (st != LS_I) r.nxt = LS_I;
      if (st == LS_M || st == LS_E) begin
        r.flush  = 1'b1;
        r.mem_wr = (st == LS_M);
      end
    end
    return r;
  endfunction

  // State a completed miss installs.
  function automatic line_st_e fill_state(logic is_wr, logic others_hold);
    if (is_wr) return LS_M;
    return others_hold ? LS_S : LS_E;
  endfunction

  // A write may complete without the bus only when no other copy can exist.
  function automatic logic silent_write_ok(line_st_e st);
    return (st == LS_E) || (st == LS_M);
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_ctl_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  line_st_e          st_q   [NUM_LINES];
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  logic [DATA_W-1:0] data_q [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_I;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_full) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              ev_fire,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  output logic              snp_hit,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output line_st_e          st_nxt,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data,
  output logic              flush_mem_wr
);

  snp_resp_t resp;
  logic      sup_now;

  assign snp_hit = snp_valid && (line_st != LS_I) &&
                   (line_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign resp    = snoop_react(line_st, bus_cmd_e'(snp_cmd));
  assign sup_now = snp_hit && resp.flush;
  assign st_we   = snp_hit && (resp.nxt != line_st);
  assign st_idx  = snp_addr[IDX_W-1:0];
  assign st_nxt  = resp.nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_out   <= 1'b0;
      flush_valid  <= 1'b0;
      flush_addr   <= '0;
      flush_data   <= '0;
      flush_mem_wr <= 1'b0;
    end else begin
      shared_out   <= snp_hit && resp.shared;
      flush_valid  <= sup_now || ev_fire;
      flush_mem_wr <= 1'b0;
      if (sup_now) begin
        flush_addr   <= snp_addr;
        flush_data   <= line_data;
        flush_mem_wr <= resp.mem_wr;
      end else if (ev_fire) begin
        flush_addr   <= ev_addr;
        flush_data   <= ev_data;
        flush_mem_wr <= 1'b1;
      end
    end
  end

  p_evict_not_with_snoop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && ev_fire));

  p_dirty_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && line_st == LS_M |=> flush_valid && flush_mem_wr);

  p_shared_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && line_st == LS_S |=> !flush_valid);

  p_read_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && snp_cmd == BC_RD |=> shared_out);

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_hit |=> !shared_out && !flush_valid);

endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
  import mesi_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic              shared_in,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  output logic              pr_we,
  output logic              pr_full,
  output line_st_e          pr_st,
  output logic [TAG_W-1:0]  pr_tag,
  output logic [DATA_W-1:0] pr_data,
  output logic              ev_fire,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);

  typedef enum logic [2:0] {
    P_IDLE, P_EVICT, P_REQ, P_SAMPLE, P_WAIT, P_INSTALL
  } pst_e;

  pst_e              ps_q;
  logic              rq_we_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [DATA_W-1:0] fill_q;
  logic [DATA_W-1:0] rdata_q;
  logic              shr_q;
  logic              ready_q;

  logic [TAG_W-1:0]  in_tag;
  logic [TAG_W-1:0]  rq_tag;
  logic              in_hit;
  logic              accept;
  logic              rd_hit;
  logic              wr_silent;
  logic              miss_start;
  logic              victim_dirty;
  logic              install_fire;

  assign in_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign rq_tag = rq_addr_q[ADDR_W-1:IDX_W];
  assign lk_idx = (ps_q == P_IDLE) ? cpu_addr[IDX_W-1:0] : rq_addr_q[IDX_W-1:0];

  // Processor work yields to any snoop in the same cycle.
  assign in_hit       = (line_st != LS_I) && (line_tag == in_tag);
  assign accept       = (ps_q == P_IDLE) && cpu_req && !snp_valid && !ready_q;
  assign rd_hit       = accept && in_hit && !cpu_we;
  assign wr_silent    = accept && in_hit && cpu_we && silent_write_ok(line_st);
  assign miss_start   = accept && !rd_hit && !wr_silent;
  assign victim_dirty = (line_st == LS_M) && (line_tag != rq_tag);
  assign ev_fire      = (ps_q == P_EVICT) && !snp_valid && victim_dirty;
  assign install_fire = (ps_q == P_INSTALL) && !snp_valid;

  assign pr_we   = wr_silent || ev_fire || install_fire;
  assign pr_full = wr_silent || install_fire;
  assign pr_tag  = wr_silent ? in_tag : rq_tag;
  assign pr_st   = ev_fire ? LS_I : (wr_silent ? LS_M : fill_state(rq_we_q, shr_q));
  assign pr_data = wr_silent ? cpu_wdata : (rq_we_q ? rq_wdata_q : fill_q);
  assign ev_addr = {line_tag, lk_idx};
  assign ev_data = line_data;

  assign bus_req_valid = (ps_q == P_REQ);
  assign bus_req_cmd   = rq_we_q ? BC_RDX : BC_RD;
  assign bus_req_addr  = rq_addr_q;
  assign cpu_ready     = ready_q;
  assign cpu_rdata     = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q       <= P_IDLE;
      rq_we_q    <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      fill_q     <= '0;
      rdata_q    <= '0;
      shr_q      <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (ps_q)
        P_IDLE: begin
          if (rd_hit) begin
            rdata_q <= line_data;
            ready_q <= 1'b1;
          end else if (wr_silent) begin
            rdata_q <= cpu_wdata;
            ready_q <= 1'b1;
          end else if (miss_start) begin
            rq_we_q    <= cpu_we;
            rq_addr_q  <= cpu_addr;
            rq_wdata_q <= cpu_wdata;
            ps_q       <= P_EVICT;
          end
        end
        P_EVICT:  if (!snp_valid) ps_q <= P_REQ;
        P_REQ:    if (bus_gnt) ps_q <= P_SAMPLE;
        P_SAMPLE: begin
          shr_q <= shared_in;
          if (bus_fill_valid) begin
            fill_q <= bus_fill_data;
            ps_q   <= P_INSTALL;
          end else begin
            ps_q <= P_WAIT;
          end
        end
        P_WAIT: begin
          if (bus_fill_valid) begin
            fill_q <= bus_fill_data;
            ps_q   <= P_INSTALL;
          end
        end
        P_INSTALL: begin
          if (install_fire) begin
            rdata_q <= pr_data;
            ready_q <= 1'b1;
            ps_q    <= P_IDLE;
          end
        end
        default: ps_q <= P_IDLE;
      endcase
    end
  end

  p_silent_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_silent |=> cpu_ready && !bus_req_valid);

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_cmd));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_no_dirty_victim_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !(line_st == LS_M && line_tag != rq_tag));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              shared_in,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data,
  output logic              flush_mem_wr
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  line_st_e          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              pr_we, pr_full;
  line_st_e          pr_st;
  logic [TAG_W-1:0]  pr_tag;
  logic [DATA_W-1:0] pr_data;
  logic              ev_fire;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;

  logic              snp_hit;
  logic              snp_st_we;
  logic [IDX_W-1:0]  snp_st_idx;
  line_st_e          snp_st_nxt;

  logic              wr_en, wr_full;
  logic [IDX_W-1:0]  wr_idx;
  line_st_e          wr_st;

  // Single write port: snoop updates win; the processor side never writes
  // while a snoop is present.
  assign wr_en   = snp_st_we || pr_we;
  assign wr_full = !snp_st_we && pr_full;
  assign wr_idx  = snp_st_we ? snp_st_idx : lk_idx;
  assign wr_st   = snp_st_we ? snp_st_nxt : pr_st;

  mesi_line_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .wr_en(wr_en), .wr_full(wr_full), .wr_idx(wr_idx), .wr_st(wr_st),
    .wr_tag(pr_tag), .wr_data(pr_data)
  );

  mesi_proc_fsm #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_proc (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .lk_idx(lk_idx),
    .line_st(a_st), .line_tag(a_tag), .line_data(a_data),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_gnt(bus_gnt), .shared_in(shared_in),
    .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .pr_we(pr_we), .pr_full(pr_full), .pr_st(pr_st), .pr_tag(pr_tag), .pr_data(pr_data),
    .ev_fire(ev_fire), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  mesi_snoop_unit #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .line_st(b_st), .line_tag(b_tag), .line_data(b_data),
    .ev_fire(ev_fire), .ev_addr(ev_addr), .ev_data(ev_data),
    .snp_hit(snp_hit), .st_we(snp_st_we), .st_idx(snp_st_idx), .st_nxt(snp_st_nxt),
    .shared_out(shared_out), .flush_valid(flush_valid), .flush_addr(flush_addr),
    .flush_data(flush_data), .flush_mem_wr(flush_mem_wr)
  );

  p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_st_we && pr_we));

  p_snoop_change_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_st_we |-> snp_hit);

endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req_valid;
  logic [1:0]    bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic          bus_gnt = 1'b0, bus_fill_valid = 1'b0;
  logic [DW-1:0] bus_fill_data = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          shared_in = 1'b0;
  logic          shared_out, flush_valid, flush_mem_wr;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_gnt(bus_gnt), .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .shared_in(shared_in), .shared_out(shared_out),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data),
    .flush_mem_wr(flush_mem_wr)
  );

  // Nibbles: req, kind(1 rd,2 wr,3 snoop rd,4 snoop rdx), addr, wdata/fill,
  // shared_in, expected bus cmd, expected data, flush, mem_wr, shared_out.
  localparam logic [51:0] VEC [NV] = '{
    52'h2_1_10_A1_0_1_A1_0_0_0,  // R2 unshared read miss -> E
    52'h3_2_10_B2_0_0_B2_0_0_0,  // R3 silent E->M write
    52'h5_3_10_00_0_0_B2_1_1_1,  // R5 snoop read on M
    52'h9_3_10_00_0_0_00_0_0_1,  // R9 snoop read on S
    52'h4_2_10_C3_0_2_C3_0_0_0,  // R4 write to S
    52'h7_4_10_00_0_0_C3_1_1_0,  // R7 snoop rdx on M
    52'hA_3_10_00_0_0_00_0_0_0,  // R10 line now invalid
    52'h2_1_21_5E_1_1_5E_0_0_0,  // R2 shared read miss -> S
    52'hB_1_21_00_0_0_5E_0_0_0,  // R11 read hit
    52'h8_4_21_00_0_0_00_0_0_0,  // R8 snoop rdx on S
    52'h8_1_21_66_1_1_66_0_0_0,  // R8 line was invalidated, misses again
    52'h2_1_22_77_0_1_77_0_0_0,  // R2 -> E
    52'hA_3_32_00_0_0_00_0_0_0,  // R10 same index, other tag
    52'h6_3_22_00_0_0_77_1_0_1,  // R6 snoop read on E
    52'h4_2_22_5A_0_2_5A_0_0_0,  // R4 write to S
    52'h5_3_22_00_0_0_5A_1_1_1,  // R5 snoop read on M
    52'h2_1_23_44_0_1_44_0_0_0,  // R2 -> E
    52'h7_4_23_00_0_0_44_1_0_0,  // R7 snoop rdx on E
    52'h4_2_24_99_0_2_99_0_0_0,  // R4 write to I
    52'h3_2_24_9B_0_0_9B_0_0_0   // R3 write to M stays silent
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [7:0] a, input logic [7:0] d,
                            input logic shr, output logic [1:0] cmd, output logic [7:0] ra,
                            output logic [7:0] rd, output logic fl, output logic [7:0] fa,
                            output logic [7:0] fd, output logic fmw, output logic fl_first,
                            output logic got);
    int ph = 0;
    int hold = 0;
    cmd = 0; ra = 0; rd = 0; fl = 0; fa = 0; fd = 0; fmw = 0; fl_first = 0; got = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; shared_in = !shr;
    for (int c = 0; c < 60 && !got; c++) begin
      @(negedge clk);
      if (flush_valid) begin
        fl = 1'b1; fa = flush_addr; fd = flush_data; fmw = flush_mem_wr;
        if (cmd == 2'd0) fl_first = 1'b1;
      end
      if (cpu_ready) begin
        rd = cpu_rdata; got = 1'b1; cpu_req = 1'b0;
      end else begin
        case (ph)
          0: if (bus_req_valid) begin
               if (cmd == 2'd0) begin cmd = bus_req_cmd; ra = bus_req_addr; end
               hold++;
               if (hold == 3) begin bus_gnt = 1'b1; ph = 1; end
             end
          1: begin bus_gnt = 1'b0; shared_in = shr; ph = 2; end
          2: begin shared_in = !shr; bus_fill_valid = 1'b1; bus_fill_data = d; ph = 3; end
          default: bus_fill_valid = 1'b0;
        endcase
      end
    end
    cpu_req = 1'b0; bus_gnt = 1'b0; bus_fill_valid = 1'b0; shared_in = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, output logic fl,
                       output logic [7:0] fd, output logic fmw, output logic sh);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    fl = flush_valid; fd = flush_data; fmw = flush_mem_wr; sh = shared_out;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] cmd;
    logic [7:0] ra, rd, fa, fd;
    logic fl, fmw, ff, got, sh;

    repeat (3) @(negedge clk);
    // R1: quiet outputs after reset
    check("R1 cpu_ready", cpu_ready, 0);
    check("R1 bus_req_valid", bus_req_valid, 0);
    check("R1 flush_valid", flush_valid, 0);
    check("R1 shared_out", shared_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    snoop(2'd1, 8'h10, fl, fd, fmw, sh);
    check("R1 snoop after reset flush", fl, 0);
    check("R1 snoop after reset shared", sh, 0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[51:48], i);
      if (v[47:44] <= 4'd2) begin
        cpu_access(v[47:44] == 4'd2, v[43:36], v[35:28], v[24], cmd, ra, rd, fl, fa, fd, fmw, ff, got);
        check({tg, " done"}, got, 1);
        check({tg, " bus cmd"}, cmd, v[21:20]);
        if (v[23:20] != 0) check({tg, " bus addr"}, ra, v[43:36]);
        check({tg, " rdata"}, rd, v[19:12]);
        check({tg, " no flush"}, fl, 0);
      end else begin
        snoop(v[47:44] == 4'd3 ? 2'd1 : 2'd2, v[43:36], fl, fd, fmw, sh);
        check({tg, " flush"}, fl, v[8]);
        if (v[8]) begin
          check({tg, " flush data"}, fd, v[19:12]);
          check({tg, " mem_wr"}, fmw, v[4]);
        end
        check({tg, " shared_out"}, sh, v[0]);
      end
    end

    // R12: index 0 holds 0x24 Modified (data 9B); a miss to 0x34 displaces it
    cpu_access(1'b0, 8'h34, 8'h12, 1'b0, cmd, ra, rd, fl, fa, fd, fmw, ff, got);
    check("R12 victim flushed", fl, 1);
    check("R12 victim addr", fa, 8'h24);
    check("R12 victim data", fd, 8'h9B);
    check("R12 victim mem_wr", fmw, 1);
    check("R12 flush before request", ff, 1);
    check("R12 bus cmd read", cmd, 2'd1);
    check("R12 fill data", rd, 8'h12);
    snoop(2'd1, 8'h24, fl, fd, fmw, sh);
    check("R12 victim gone flush", fl, 0);
    check("R12 victim gone shared", sh, 0);
    snoop(2'd1, 8'h34, fl, fd, fmw, sh);
    check("R2 new line installed E flush", fl, 1);
    check("R2 new line installed E mem_wr", fmw, 0);

    // R1: reset mid-life clears every line
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    snoop(2'd1, 8'h34, fl, fd, fmw, sh);
    check("R1 reset invalidates flush", fl, 0);
    check("R1 reset invalidates shared", sh, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule